// File: doc/BRIEF.md
# Banked Data Pointer Unit

This block holds four 24-bit data pointers for an 8-bit microcontroller core. Each pointer is split into a low byte (address bits 7..0), a middle byte (bits 15..8) and a high byte (bits 23..16). Each of those bytes is a special-function register on an 8-bit read/write port, so software can load or inspect any pointer one byte at a time.

A 2-bit select input names the active pointer, and the active pointer's full 24-bit value is always driven on the pointer output. When the core pulses the step strobe, the active pointer moves by one. Pointers 0 and 1 always count up. Pointers 2 and 3 each have their own direction bit in a shared direction register, so the same strobe can count one pointer down and another up. The carry or borrow ripples through all three bytes in the same cycle, and the result wraps modulo 2^24.

Instruction decode, the register that holds the select value, and memory access all live outside this block. The block is purely datapath and decode. It has no state machine.

Top module: `dptr_bank`

## Requirements
- R1: Each of the twelve pointer bytes can be written and read back at its own address (lo/mid/hi). Pointer 0 uses 0x82/0x83/0x86, pointer 1 uses 0x84/0x85/0x87, pointer 2 uses 0xF2/0xF3/0xF8 and pointer 3 uses 0xF4/0xF5/0xF9. The low byte is bits 7..0, the middle byte is bits 15..8 and the high byte is bits 23..16.
- R2: `dptr_out` shows the full 24-bit value of the pointer whose index equals `sel`, with no delay.
- R3: A step on pointer 0 or pointer 1 always adds one. 0xFFFFFF wraps to 0x000000.
- R4: When its direction bit is 0, a step on pointer 2 or pointer 3 adds one, with the carry crossing byte boundaries in one cycle (0x00FFFF becomes 0x010000).
- R5: When its direction bit is 1, a step on pointer 2 or pointer 3 subtracts one, with the borrow crossing bytes (0x010000 becomes 0x00FFFF and 0x000000 becomes 0xFFFFFF). Bit 7 of the direction register at 0xF6 serves pointer 3, and bit 6 serves pointer 2.
- R6: Reading the direction register returns the two direction bits in bits 7..6 and ones in bits 5..0. Writes to bits 5..0 are ignored.
- R7: After reset, every pointer byte and both direction bits are 0.
- R8: If a byte write and a step target the same pointer in the same cycle, the written byte takes the write data. The other bytes of that pointer keep their old value, and no step is applied.
- R9: `sfr_hit` is 1 for any mapped address. A read from an unmapped address returns 0x00 with `sfr_hit` at 0.
- R10: A step changes only the active pointer. Without a step or a write, the output for an unchanged `sel` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wr | input | 1 | Write enable for the addressed register |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr`, combinational |
| sfr_hit | output | 1 | `sfr_addr` belongs to a register of this block |
| sel | input | 2 | Index of the active pointer |
| inc_stb | input | 1 | Step the active pointer by one in its direction |
| dptr_out | output | 24 | Value of the active pointer |

## Verification
On every cycle, the assertions check the following:
- a step moves the active pointer by exactly one, in the direction its bit selects;
- the output holds when nothing happens;
- a colliding write beats the step on the low byte;
- the reserved direction bits always read as ones;
- unmapped reads return zero.

Only the bench's scenarios can show the rest:
- the full address map read back byte by byte;
- the wrap corners 0xFFFFFF→0 and 0→0xFFFFFF;
- the fact that stepping one pointer leaves the stored bytes of the others untouched, as seen through register reads.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
    localparam int BYTE_W    = 8;
    localparam int PTR_BYTES = 3;
    localparam int PTR_W     = BYTE_W * PTR_BYTES;
    localparam int N_PTR     = 4;
    localparam int SEL_W     = $clog2(N_PTR);
    localparam int N_DIR     = 2;              // pointers 2 and 3 carry a direction bit
    localparam int FIRST_DIR = N_PTR - N_DIR;  // index of first pointer with direction bit

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef enum logic [1:0] {
        LANE_LO  = 2'd0,
        LANE_MID = 2'd1,
        LANE_HI  = 2'd2
    } lane_e;

    // address tables, pointer i at bits [i*8 +: 8]
    localparam logic [N_PTR*BYTE_W-1:0] DEF_LO_ADDRS  = {8'hF4, 8'hF2, 8'h84, 8'h82};
    localparam logic [N_PTR*BYTE_W-1:0] DEF_MID_ADDRS = {8'hF5, 8'hF3, 8'h85, 8'h83};
    localparam logic [N_PTR*BYTE_W-1:0] DEF_HI_ADDRS  = {8'hF9, 8'hF8, 8'h87, 8'h86};
    localparam byte_t                   DEF_DIR_ADDR  = 8'hF6;
endpackage

// File: rtl/dptr_step.sv
module dptr_step
    import dptr_pkg::*;
#(
    parameter int W = PTR_W
) (
    input  logic [W-1:0] cur,
    input  logic         down,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        if (down) nxt = cur - ONE;
        else      nxt = cur + ONE;
    end
endmodule

// File: rtl/dptr_slot.sv
module dptr_slot
    import dptr_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int NB = PTR_BYTES,
    localparam int W = BW * NB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] byte_we,
    input  logic [BW-1:0] wdata,
    input  logic          step_en,
    input  logic          step_dn,
    output logic [W-1:0]  q
);
    logic [W-1:0] stepped;
    logic [W-1:0] d;

    dptr_step #(.W(W)) u_step (
        .cur  (q),
        .down (step_dn),
        .nxt  (stepped)
    );

    always_comb begin
        d = q;
        if (|byte_we) begin
            for (int b = 0; b < NB; b++) begin
                if (byte_we[b]) d[b*BW +: BW] = wdata;
            end
        end else if (step_en) begin
            d = stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/dptr_decode.sv
module dptr_decode
    import dptr_pkg::*;
#(
    parameter int                         NP        = N_PTR,
    parameter int                         BW        = BYTE_W,
    parameter logic [NP*BW-1:0]           LO_ADDRS  = DEF_LO_ADDRS,
    parameter logic [NP*BW-1:0]           MID_ADDRS = DEF_MID_ADDRS,
    parameter logic [NP*BW-1:0]           HI_ADDRS  = DEF_HI_ADDRS,
    parameter logic [BW-1:0]              DIR_ADDR  = DEF_DIR_ADDR
) (
    input  logic [BW-1:0]          addr,
    output logic [NP*PTR_BYTES-1:0] byte_hit,   // pointer i, lane b at i*PTR_BYTES+b
    output logic                   dir_hit
);
    for (genvar i = 0; i < NP; i++) begin : g_ptr
        assign byte_hit[i*PTR_BYTES + LANE_LO]  = (addr == LO_ADDRS[i*BW +: BW]);
        assign byte_hit[i*PTR_BYTES + LANE_MID] = (addr == MID_ADDRS[i*BW +: BW]);
        assign byte_hit[i*PTR_BYTES + LANE_HI]  = (addr == HI_ADDRS[i*BW +: BW]);
    end

    assign dir_hit = (addr == DIR_ADDR);
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank
    import dptr_pkg::*;
#(
    parameter logic [N_PTR*BYTE_W-1:0] LO_ADDRS  = DEF_LO_ADDRS,
    parameter logic [N_PTR*BYTE_W-1:0] MID_ADDRS = DEF_MID_ADDRS,
    parameter logic [N_PTR*BYTE_W-1:0] HI_ADDRS  = DEF_HI_ADDRS,
    parameter logic [BYTE_W-1:0]       DIR_ADDR  = DEF_DIR_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [BYTE_W-1:0] sfr_wdata,
    output logic [BYTE_W-1:0] sfr_rdata,
    output logic              sfr_hit,
    input  logic [SEL_W-1:0]  sel,
    input  logic              inc_stb,
    output logic [PTR_W-1:0]  dptr_out
);
    localparam int RSV_W = BYTE_W - N_DIR;

    logic [N_PTR*PTR_BYTES-1:0] byte_hit;
    logic                       dir_hit;
    logic [N_DIR-1:0]           dir_q;     // [1] pointer 3, [0] pointer 2
    logic [N_PTR-1:0][PTR_W-1:0] ptr_q;

    dptr_decode #(
        .NP        (N_PTR),
        .BW        (BYTE_W),
        .LO_ADDRS  (LO_ADDRS),
        .MID_ADDRS (MID_ADDRS),
        .HI_ADDRS  (HI_ADDRS),
        .DIR_ADDR  (DIR_ADDR)
    ) u_dec (
        .addr     (sfr_addr),
        .byte_hit (byte_hit),
        .dir_hit  (dir_hit)
    );

    for (genvar i = 0; i < N_PTR; i++) begin : g_slot
        logic dn;
        if (i >= FIRST_DIR) begin : g_dir
            assign dn = dir_q[i-FIRST_DIR];
        end else begin : g_up
            assign dn = 1'b0;
        end

        dptr_slot #(.BW(BYTE_W), .NB(PTR_BYTES)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .byte_we ({PTR_BYTES{sfr_wr}} & byte_hit[i*PTR_BYTES +: PTR_BYTES]),
            .wdata   (sfr_wdata),
            .step_en (inc_stb && (sel == SEL_W'(i))),
            .step_dn (dn),
            .q       (ptr_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                dir_q <= '0;
        else if (sfr_wr && dir_hit) dir_q <= sfr_wdata[BYTE_W-1 -: N_DIR];
    end

    always_comb begin
        sfr_rdata = '0;
        for (int i = 0; i < N_PTR; i++) begin
            for (int b = 0; b < PTR_BYTES; b++) begin
                if (byte_hit[i*PTR_BYTES + b]) sfr_rdata = ptr_q[i][b*BYTE_W +: BYTE_W];
            end
        end
        if (dir_hit) sfr_rdata = {dir_q, {RSV_W{1'b1}}};
    end

    assign sfr_hit  = (|byte_hit) | dir_hit;
    assign dptr_out = ptr_q[sel];
endmodule

// File: rtl/dptr_bank_chk.sv
module dptr_bank_chk
    import dptr_pkg::*;
#(
    parameter logic [N_PTR*BYTE_W-1:0] LO_ADDRS = DEF_LO_ADDRS,
    parameter logic [BYTE_W-1:0]       DIR_ADDR = DEF_DIR_ADDR
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] sfr_addr,
    input logic              sfr_wr,
    input logic [BYTE_W-1:0] sfr_wdata,
    input logic [BYTE_W-1:0] sfr_rdata,
    input logic              sfr_hit,
    input logic [SEL_W-1:0]  sel,
    input logic              inc_stb,
    input logic [PTR_W-1:0]  dptr_out,
    input logic [N_DIR-1:0]  dir_q
);
    logic act_down;
    always_comb begin
        act_down = 1'b0;
        if (sel == 2'd3) act_down = dir_q[1];
        if (sel == 2'd2) act_down = dir_q[0];
    end

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> dptr_out == '0);  // R7

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        inc_stb && !sfr_wr && !act_down |=>
            (sel != $past(sel)) || (dptr_out == $past(dptr_out) + 24'd1));  // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        inc_stb && !sfr_wr && act_down |=>
            (sel != $past(sel)) || (dptr_out == $past(dptr_out) - 24'd1));  // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_stb && !sfr_wr |=> (sel != $past(sel)) || $stable(dptr_out));  // R10

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr && inc_stb && (sfr_addr == LO_ADDRS[sel*BYTE_W +: BYTE_W]) |=>
            (sel != $past(sel)) ||
            (dptr_out == {$past(dptr_out[PTR_W-1:BYTE_W]), $past(sfr_wdata)}));  // R8

    AST_DIR_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_addr == DIR_ADDR |-> sfr_rdata[BYTE_W-N_DIR-1:0] == '1);  // R6

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_hit |-> sfr_rdata == '0);  // R9
endmodule

bind dptr_bank dptr_bank_chk u_chk (.*);

// File: tb/tb_dptr_bank.sv
module tb_dptr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        sfr_hit;
    logic [1:0]  sel = 2'd0;
    logic        inc_stb = 1'b0;
    logic [23:0] dptr_out;

    int checks = 0;
    int failures = 0;

    // lo, mid, hi address of each pointer, as listed in R1
    logic [7:0] a_lo  [4] = '{8'h82, 8'h84, 8'hF2, 8'hF4};
    logic [7:0] a_mid [4] = '{8'h83, 8'h85, 8'hF3, 8'hF5};
    logic [7:0] a_hi  [4] = '{8'h86, 8'h87, 8'hF8, 8'hF9};
    localparam logic [7:0] DIR_A = 8'hF6;

    always #2 clk = ~clk;

    dptr_bank dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit),
        .sel(sel), .inc_stb(inc_stb), .dptr_out(dptr_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic h);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
        h = sfr_hit;
    endtask

    task automatic load(input int p, input logic [23:0] v);
        wr(a_lo[p], v[7:0]);
        wr(a_mid[p], v[15:8]);
        wr(a_hi[p], v[23:16]);
    endtask

    task automatic step(input logic [1:0] s);
        @(negedge clk);
        sel = s; inc_stb = 1'b1;
        @(negedge clk);
        inc_stb = 1'b0;
    endtask

    task automatic see(input string req, input logic [1:0] s, input logic [23:0] exp);
        sel = s;
        #1;
        chk(req, {8'h0, dptr_out}, {8'h0, exp});
    endtask

    task automatic t_reset();
        logic [7:0] d; logic h;
        for (int p = 0; p < 4; p++) see("R7 ptr zero", 2'(p), 24'h0);
        rd(DIR_A, d, h);
        chk("R7/R6 dir reset read", {24'h0, d}, 32'h3F);
        rd(a_hi[3], d, h);
        chk("R7 byte zero", {24'h0, d}, 32'h0);
    endtask

    task automatic t_map();
        logic [7:0] d; logic h;
        for (int p = 0; p < 4; p++) begin
            wr(a_lo[p],  8'h10 + 8'(p));
            wr(a_mid[p], 8'h20 + 8'(p));
            wr(a_hi[p],  8'h30 + 8'(p));
        end
        for (int p = 0; p < 4; p++) begin
            rd(a_lo[p], d, h);  chk("R1 lo readback",  {24'h0, d}, 32'h10 + p);
            chk("R9 hit on mapped", {31'h0, h}, 32'h1);
            rd(a_mid[p], d, h); chk("R1 mid readback", {24'h0, d}, 32'h20 + p);
            rd(a_hi[p], d, h);  chk("R1 hi readback",  {24'h0, d}, 32'h30 + p);
        end
    endtask

    task automatic t_select();
        for (int p = 0; p < 4; p++)
            see("R2 select", 2'(p), {8'h30 + 8'(p), 8'h20 + 8'(p), 8'h10 + 8'(p)});
    endtask

    task automatic t_up_fixed();
        load(0, 24'hFFFFFF);
        step(2'd0);
        see("R3 ptr0 wrap", 2'd0, 24'h000000);
        load(1, 24'h0000FF);
        step(2'd1);
        see("R3 ptr1 carry", 2'd1, 24'h000100);
    endtask

    task automatic t_dir();
        logic [7:0] d; logic h;
        wr(DIR_A, 8'h00);
        load(2, 24'h00FFFF);
        step(2'd2);
        see("R4 ptr2 up carry", 2'd2, 24'h010000);
        wr(DIR_A, 8'h80);
        rd(DIR_A, d, h);
        chk("R6 dir read p3 down", {24'h0, d}, 32'hBF);
        load(3, 24'h010000);
        step(2'd3);
        see("R5 ptr3 down borrow", 2'd3, 24'h00FFFF);
        load(3, 24'h000000);
        step(2'd3);
        see("R5 ptr3 down wrap", 2'd3, 24'hFFFFFF);
        step(2'd2);
        see("R4 ptr2 still up", 2'd2, 24'h010001);
        wr(DIR_A, 8'h40);
        rd(DIR_A, d, h);
        chk("R6 reserved ignore write", {24'h0, d}, 32'h7F);
        step(2'd2);
        see("R5 ptr2 down via bit6", 2'd2, 24'h010000);
        step(2'd3);
        see("R4 ptr3 up after clear", 2'd3, 24'h000000);
    endtask

    task automatic t_collide();
        load(1, 24'h123410);
        @(negedge clk);
        sel = 2'd1; inc_stb = 1'b1;
        sfr_addr = a_lo[1]; sfr_wdata = 8'h55; sfr_wr = 1'b1;
        @(negedge clk);
        inc_stb = 1'b0; sfr_wr = 1'b0;
        see("R8 write wins", 2'd1, 24'h123455);
    endtask

    task automatic t_isolation();
        logic [7:0] d; logic h;
        load(3, 24'hABCDEF);
        load(2, 24'h000001);
        step(2'd2);
        rd(a_lo[3], d, h);  chk("R10 other lo kept",  {24'h0, d}, 32'hEF);
        rd(a_mid[3], d, h); chk("R10 other mid kept", {24'h0, d}, 32'hCD);
        rd(a_hi[3], d, h);  chk("R10 other hi kept",  {24'h0, d}, 32'hAB);
        see("R10 hold idle", 2'd2, 24'h000000);
        repeat (3) @(negedge clk);
        see("R10 hold idle later", 2'd2, 24'h000000);
    endtask

    task automatic t_unmapped();
        logic [7:0] d; logic h;
        rd(8'h00, d, h);
        chk("R9 unmapped data", {24'h0, d}, 32'h0);
        chk("R9 unmapped hit", {31'h0, h}, 32'h0);
        rd(8'hF7, d, h);
        chk("R9 gap hit", {31'h0, h}, 32'h0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_select();
        t_up_fixed();
        t_dir();
        t_collide();
        t_isolation();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule